// File: doc/BRIEF.md
# Calendar Real-Time Clock with Alarm

This block keeps wall-clock time and date from a 32.768 kHz time base. A prescaler turns qualified base-clock cycles into one-second steps, and a calendar chain carries each step through seconds, minutes, hours, day of week, day of month, month and a two-digit year (2000 to 2099). February gets its leap-day length in years divisible by four. Base cycles arrive as an enable (`tick_en`) on the system clock, so the block needs only one clock domain.

Software reaches the block over a simple byte-wide register bus. Writing a time field sets it directly. Reading the seconds field freezes a copy of every time field, so a sequence of reads returns one consistent instant. An alarm compares a chosen subset of fields against the time each time the time advances. A match sets a sticky flag, which can drive an interrupt, an output pin, or both. A signed trim value lengthens or shortens one second per minute by a number of base cycles, to make up for crystal error.

Top module: `cal_rtc`

## Requirements
- R1: Seconds advance once every DIV_COUNT cycles in which `tick_en` is high. Cycles with `tick_en` low do not count. A write to address 0 restarts the prescaler from zero.
- R2: Seconds and minutes run 0 to 59 and hours run 0 to 23. Each field carries into the next when it wraps.
- R3: The day of month wraps to 1 after its month's last day. The lengths are 31 for months 1, 3, 5, 7, 8, 10 and 12, 30 for months 4, 6, 9 and 11, and 29 for month 2 when year mod 4 is 0, otherwise 28.
- R4: The day of week (0 to 6) steps at midnight and wraps 6 to 0. Month 12 wraps to 1, and that carries into the year, which wraps 99 to 0.
- R5: Alarm mask bits are bit0 seconds, bit1 minutes, bit2 hours, bit3 day of week and bit4 day of month. The alarm flag is set on an advance whose new time equals the alarm value in every enabled field. Disabled fields are ignored, and a mask of 0 never matches.
- R6: The flag stays set until software writes 1 to control bit0 (address 14). If a clear and a set happen in the same cycle, the set wins.
- R7: `irq` is the flag ANDed with control bit1. `alarm_pin` is the flag ANDed with control bit2.
- R8: The trim register (address 13) holds a signed 8-bit value. While seconds reads 0, that second lasts DIV_COUNT + trim qualified cycles.
- R9: Read data appears one cycle after `rd_en`. Address 0 returns the live seconds and copies all seven time fields into a holding register. Addresses 1 to 6 return the held minutes, hours, day of week, day of month, month and year.
- R10: Addresses 0 to 6 set seconds, minutes, hours, day of week, day of month, month and year. Addresses 7 to 11 set the alarm seconds, minutes, hours, day of week and day of month. Address 12 is the mask. If a time write lands in the cycle of a second step, the write wins and that step is dropped.
- R11: After reset the time is 00:00:00, day of week 0, day 1, month 1, year 0. The alarm, mask, trim and control registers are 0, and `irq` and `alarm_pin` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | One pulse per 32.768 kHz base cycle |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Register address |
| wr_data | input | DATA_W | Write data |
| rd_data | output | DATA_W | Read data, valid one cycle after rd_en |
| irq | output | 1 | Alarm interrupt |
| alarm_pin | output | 1 | Alarm output pin |

## Verification
The bench builds the block with DIV_COUNT set to 150 and leaves the 8-bit trim width as it is. A second therefore takes 150 cycles, and each rollover chain can be reached by writing fields just below their wrap point and waiting one second. The short second also brings trims of plus and minus ten within reach: they shift a step by a visible number of cycles, and the bench samples on both sides of the shifted edge. The same setting lets a time write be placed exactly on the cycle of a second step.

// File: rtl/cal_rtc_pkg.sv
package cal_rtc_pkg;

  localparam logic [3:0] A_SEC   = 4'd0;
  localparam logic [3:0] A_MIN   = 4'd1;
  localparam logic [3:0] A_HOUR  = 4'd2;
  localparam logic [3:0] A_WDAY  = 4'd3;
  localparam logic [3:0] A_DATE  = 4'd4;
  localparam logic [3:0] A_MON   = 4'd5;
  localparam logic [3:0] A_YEAR  = 4'd6;
  localparam logic [3:0] A_ASEC  = 4'd7;
  localparam logic [3:0] A_AMIN  = 4'd8;
  localparam logic [3:0] A_AHOUR = 4'd9;
  localparam logic [3:0] A_AWDAY = 4'd10;
  localparam logic [3:0] A_ADATE = 4'd11;
  localparam logic [3:0] A_MASK  = 4'd12;
  localparam logic [3:0] A_TRIM  = 4'd13;
  localparam logic [3:0] A_CTRL  = 4'd14;

  localparam int unsigned M_SEC  = 0;
  localparam int unsigned M_MIN  = 1;
  localparam int unsigned M_HOUR = 2;
  localparam int unsigned M_WDAY = 3;
  localparam int unsigned M_DATE = 4;
  localparam int unsigned MASK_W = 5;

  typedef struct packed {
    logic [6:0] year;
    logic [3:0] mon;
    logic [4:0] date;
    logic [2:0] wday;
    logic [4:0] hour;
    logic [5:0] min;
    logic [5:0] sec;
  } cal_time_t;

  typedef struct packed {
    logic [4:0] date;
    logic [2:0] wday;
    logic [4:0] hour;
    logic [5:0] min;
    logic [5:0] sec;
  } alarm_set_t;

  function automatic logic [4:0] month_days(input logic [3:0] mon, input logic [6:0] year);
    case (mon)
      4'd2:                      return (year[1:0] == 2'b00) ? 5'd29 : 5'd28;
      4'd4, 4'd6, 4'd9, 4'd11:   return 5'd30;
      default:                   return 5'd31;
    endcase
  endfunction

endpackage

// File: rtl/cal_rtc_prescale.sv
module cal_rtc_prescale #(
  parameter int unsigned DIV_COUNT = 32768,
  parameter int unsigned TRIM_W    = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     tick_en,
  input  logic                     restart,
  input  logic                     trim_now,
  input  logic signed [TRIM_W-1:0] trim,
  output logic                     sec_pulse
);
  localparam int unsigned TRIM_MAX = 1 << (TRIM_W - 1);
  localparam int unsigned CNT_W    = $clog2(DIV_COUNT + TRIM_MAX + 1);
  localparam int unsigned SPN_W    = CNT_W + 2;
  localparam logic signed [SPN_W-1:0] ONE_S = 1;

  logic [CNT_W-1:0]        cnt_q, cnt_d;
  logic signed [SPN_W-1:0] span, last, cnt_s;
  logic                    end_hit;

  always_comb begin
    span    = $signed(SPN_W'(DIV_COUNT)) + (trim_now ? SPN_W'(trim) : ONE_S - ONE_S);
    last    = span - ONE_S;
    cnt_s   = $signed({2'b00, cnt_q});
    end_hit = (cnt_s >= last);
    sec_pulse = tick_en & ~restart & end_hit;
    cnt_d = cnt_q;
    if (restart)      cnt_d = '0;
    else if (tick_en) cnt_d = end_hit ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/cal_rtc_calendar.sv
module cal_rtc_calendar
  import cal_rtc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       adv,
  input  logic       wr_en,
  input  logic [3:0] wr_addr,
  input  logic [7:0] wr_data,
  output cal_time_t  now_q,
  output cal_time_t  now_d
);
  always_comb begin
    now_d = now_q;
    if (wr_en && (wr_addr <= A_YEAR)) begin
      case (wr_addr)
        A_SEC:   now_d.sec  = wr_data[5:0];
        A_MIN:   now_d.min  = wr_data[5:0];
        A_HOUR:  now_d.hour = wr_data[4:0];
        A_WDAY:  now_d.wday = wr_data[2:0];
        A_DATE:  now_d.date = wr_data[4:0];
        A_MON:   now_d.mon  = wr_data[3:0];
        default: now_d.year = wr_data[6:0];
      endcase
    end else if (adv) begin
      if (now_q.sec != 6'd59) now_d.sec = now_q.sec + 6'd1;
      else begin
        now_d.sec = '0;
        if (now_q.min != 6'd59) now_d.min = now_q.min + 6'd1;
        else begin
          now_d.min = '0;
          if (now_q.hour != 5'd23) now_d.hour = now_q.hour + 5'd1;
          else begin
            now_d.hour = '0;
            now_d.wday = (now_q.wday == 3'd6) ? 3'd0 : now_q.wday + 3'd1;
            if (now_q.date != month_days(now_q.mon, now_q.year)) now_d.date = now_q.date + 5'd1;
            else begin
              now_d.date = 5'd1;
              if (now_q.mon != 4'd12) now_d.mon = now_q.mon + 4'd1;
              else begin
                now_d.mon  = 4'd1;
                now_d.year = (now_q.year == 7'd99) ? 7'd0 : now_q.year + 7'd1;
              end
            end
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      now_q <= '{year: 7'd0, mon: 4'd1, date: 5'd1, wday: 3'd0, hour: 5'd0, min: 6'd0, sec: 6'd0};
    end else begin
      now_q <= now_d;
    end
  end
endmodule

// File: rtl/cal_rtc_alarm.sv
module cal_rtc_alarm
  import cal_rtc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  input  cal_time_t         cand,
  input  alarm_set_t        target,
  input  logic [MASK_W-1:0] mask,
  input  logic              clr,
  output logic              flag_q
);
  logic [MASK_W-1:0] eq;
  logic              match, flag_d;

  always_comb begin
    eq[M_SEC]  = (cand.sec  == target.sec);
    eq[M_MIN]  = (cand.min  == target.min);
    eq[M_HOUR] = (cand.hour == target.hour);
    eq[M_WDAY] = (cand.wday == target.wday);
    eq[M_DATE] = (cand.date == target.date);
    match  = (mask != '0) && ((eq | ~mask) == '1);
    flag_d = flag_q;
    if (adv && match) flag_d = 1'b1;
    else if (clr)     flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end
endmodule

// File: rtl/cal_rtc.sv
module cal_rtc
  import cal_rtc_pkg::*;
#(
  parameter int unsigned DIV_COUNT = 32768,
  parameter int unsigned TRIM_W    = 8,
  parameter int unsigned ADDR_W    = 4,
  parameter int unsigned DATA_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq,
  output logic              alarm_pin
);
  cal_time_t              now_q, now_d, hold_q, hold_d;
  alarm_set_t             alm_q, alm_d;
  logic [MASK_W-1:0]      mask_q, mask_d;
  logic signed [TRIM_W-1:0] trim_q, trim_d;
  logic                   irq_en_q, irq_en_d, pin_en_q, pin_en_d;
  logic [DATA_W-1:0]      rd_q, rd_d;
  logic [3:0]             reg_a;
  logic                   time_write, sec_write, sec_pulse, adv, flag_clr, alarm_flag;

  assign reg_a      = 4'(addr);
  assign time_write = wr_en && (reg_a <= A_YEAR);
  assign sec_write  = wr_en && (reg_a == A_SEC);
  assign adv        = sec_pulse && !time_write;

  cal_rtc_prescale #(.DIV_COUNT(DIV_COUNT), .TRIM_W(TRIM_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .restart(sec_write),
    .trim_now(now_q.sec == 6'd0), .trim(trim_q), .sec_pulse(sec_pulse));

  cal_rtc_calendar u_cal (
    .clk(clk), .rst_n(rst_n), .adv(adv), .wr_en(wr_en), .wr_addr(reg_a),
    .wr_data(wr_data[7:0]), .now_q(now_q), .now_d(now_d));

  cal_rtc_alarm u_alm (
    .clk(clk), .rst_n(rst_n), .adv(adv), .cand(now_d), .target(alm_q),
    .mask(mask_q), .clr(flag_clr), .flag_q(alarm_flag));

  always_comb begin
    alm_d    = alm_q;
    mask_d   = mask_q;
    trim_d   = trim_q;
    irq_en_d = irq_en_q;
    pin_en_d = pin_en_q;
    flag_clr = 1'b0;
    if (wr_en) begin
      case (reg_a)
        A_ASEC:  alm_d.sec  = wr_data[5:0];
        A_AMIN:  alm_d.min  = wr_data[5:0];
        A_AHOUR: alm_d.hour = wr_data[4:0];
        A_AWDAY: alm_d.wday = wr_data[2:0];
        A_ADATE: alm_d.date = wr_data[4:0];
        A_MASK:  mask_d     = wr_data[MASK_W-1:0];
        A_TRIM:  trim_d     = $signed(wr_data[TRIM_W-1:0]);
        A_CTRL: begin
          flag_clr = wr_data[0];
          irq_en_d = wr_data[1];
          pin_en_d = wr_data[2];
        end
        default: ;
      endcase
    end
    hold_d = hold_q;
    rd_d   = rd_q;
    if (rd_en) begin
      case (reg_a)
        A_SEC: begin
          rd_d   = DATA_W'(now_q.sec);
          hold_d = now_q;
        end
        A_MIN:   rd_d = DATA_W'(hold_q.min);
        A_HOUR:  rd_d = DATA_W'(hold_q.hour);
        A_WDAY:  rd_d = DATA_W'(hold_q.wday);
        A_DATE:  rd_d = DATA_W'(hold_q.date);
        A_MON:   rd_d = DATA_W'(hold_q.mon);
        A_YEAR:  rd_d = DATA_W'(hold_q.year);
        A_ASEC:  rd_d = DATA_W'(alm_q.sec);
        A_AMIN:  rd_d = DATA_W'(alm_q.min);
        A_AHOUR: rd_d = DATA_W'(alm_q.hour);
        A_AWDAY: rd_d = DATA_W'(alm_q.wday);
        A_ADATE: rd_d = DATA_W'(alm_q.date);
        A_MASK:  rd_d = DATA_W'(mask_q);
        A_TRIM:  rd_d = DATA_W'($unsigned(trim_q));
        A_CTRL:  rd_d = DATA_W'({pin_en_q, irq_en_q, alarm_flag});
        default: rd_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alm_q    <= '0;
      mask_q   <= '0;
      trim_q   <= '0;
      irq_en_q <= 1'b0;
      pin_en_q <= 1'b0;
      hold_q   <= '0;
      rd_q     <= '0;
    end else begin
      alm_q    <= alm_d;
      mask_q   <= mask_d;
      trim_q   <= trim_d;
      irq_en_q <= irq_en_d;
      pin_en_q <= pin_en_d;
      hold_q   <= hold_d;
      rd_q     <= rd_d;
    end
  end

  assign rd_data   = rd_q;
  assign irq       = alarm_flag & irq_en_q;
  assign alarm_pin = alarm_flag & pin_en_q;
endmodule

// File: rtl/cal_rtc_chk.sv
module cal_rtc_chk
  import cal_rtc_pkg::*;
(
  input logic      clk,
  input logic      rst_n,
  input logic      adv,
  input logic      time_write,
  input logic      flag,
  input logic      clr,
  input cal_time_t now
);
  AST_STEP_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> !adv); // R1

  AST_SEC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> (now.sec == (($past(now.sec) == 6'd59) ? 6'd0 : $past(now.sec) + 6'd1))); // R2

  AST_TIME_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !time_write) |=> $stable(now)); // R10

  AST_DATE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> (now.date != 5'd0 && now.date <= month_days(now.mon, now.year))); // R3

  AST_FLAG_ON_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(adv)); // R5

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr) |=> flag); // R6
endmodule

bind cal_rtc cal_rtc_chk u_chk (
  .clk(clk), .rst_n(rst_n), .adv(adv), .time_write(time_write),
  .flag(alarm_flag), .clr(flag_clr), .now(now_q));

// File: tb/cal_rtc_tb.sv
`timescale 1ns/1ps
module cal_rtc_tb;
  localparam int DIV = 150;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 1'b0;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       irq, alarm_pin;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  cal_rtc #(.DIV_COUNT(DIV)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .irq(irq), .alarm_pin(alarm_pin));

  // behavioural reference state, indexed by register address
  int m_t[7];
  int m_h[7];
  int m_a[5];
  int m_cnt, m_mask, m_cal, m_flag, m_ie, m_pe, m_rd, m_rdv;
  int span;
  bit twr, pulse, adv, any_en, all_eq;

  function automatic int mdays(int mo, int yr);
    if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_t = '{0, 0, 0, 0, 1, 1, 0};
      for (int i = 0; i < 7; i++) m_h[i] = 0;
      for (int i = 0; i < 5; i++) m_a[i] = 0;
      m_cnt = 0; m_mask = 0; m_cal = 0; m_flag = 0; m_ie = 0; m_pe = 0;
      m_rd = 0; m_rdv = 0;
    end else begin
      twr   = wr_en && (addr <= 6);
      span  = DIV + ((m_t[0] == 0) ? m_cal : 0);
      pulse = tick_en && !(wr_en && addr == 0) && (m_cnt >= span - 1);
      adv   = pulse && !twr;
      m_rdv = rd_en;
      if (rd_en) begin
        if (addr == 0) begin
          m_rd = m_t[0];
          for (int i = 0; i < 7; i++) m_h[i] = m_t[i];
        end else if (addr <= 6) m_rd = m_h[addr];
        else if (addr <= 11) m_rd = m_a[addr - 7];
        else if (addr == 12) m_rd = m_mask;
        else if (addr == 13) m_rd = m_cal & 255;
        else if (addr == 14) m_rd = m_flag | (m_ie << 1) | (m_pe << 2);
        else m_rd = 0;
      end
      if (wr_en && addr == 0) m_cnt = 0;
      else if (tick_en) m_cnt = pulse ? 0 : m_cnt + 1;
      if (twr) m_t[addr] = int'(wr_data);
      else if (adv) begin
        m_t[0]++;
        if (m_t[0] == 60) begin
          m_t[0] = 0; m_t[1]++;
          if (m_t[1] == 60) begin
            m_t[1] = 0; m_t[2]++;
            if (m_t[2] == 24) begin
              m_t[2] = 0;
              m_t[3] = (m_t[3] + 1) % 7;
              m_t[4]++;
              if (m_t[4] > mdays(m_t[5], m_t[6])) begin
                m_t[4] = 1; m_t[5]++;
                if (m_t[5] == 13) begin
                  m_t[5] = 1;
                  m_t[6] = (m_t[6] + 1) % 100;
                end
              end
            end
          end
        end
      end
      any_en = 0; all_eq = 1;
      for (int i = 0; i < 5; i++)
        if (m_mask[i]) begin
          any_en = 1;
          if (m_t[i] != m_a[i]) all_eq = 0;
        end
      if (adv && any_en && all_eq) m_flag = 1;
      else if (wr_en && addr == 14 && wr_data[0]) m_flag = 0;
      if (wr_en) begin
        if (addr >= 7 && addr <= 11) m_a[addr - 7] = int'(wr_data);
        else if (addr == 12) m_mask = int'(wr_data[4:0]);
        else if (addr == 13) m_cal = int'($signed(wr_data));
        else if (addr == 14) begin m_ie = int'(wr_data[1]); m_pe = int'(wr_data[2]); end
      end
    end
  end

  // every-cycle comparison against the reference
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R7 irq vs model", int'(irq), m_flag & m_ie);
      chk("R7 pin vs model", int'(alarm_pin), m_flag & m_pe);
      if (m_rdv != 0) chk("R9 read vs model", int'(rd_data), m_rd);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog R1: actual %0d expected below 100000 cycles", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic wr(input int a, input int d);
    wr_en = 1'b1; addr = 4'(a); wr_data = 8'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, input int exp, input string tag);
    rd_en = 1'b1; addr = 4'(a);
    @(negedge clk);
    rd_en = 1'b0;
    chk(tag, int'(rd_data), exp);
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R11 irq in reset", int'(irq), 0);
    chk("R11 pin in reset", int'(alarm_pin), 0);
    rst_n = 1'b1;
    @(negedge clk);
    rd(0, 0, "R11 seconds");
    rd(4, 1, "R11 date");
    rd(5, 1, "R11 month");
    rd(14, 0, "R11 control");
    tick_en = 1'b1;

    // R1 second step and restart
    wr(0, 5);
    wait_n(DIV - 1);
    rd(0, 5, "R1 before step");
    rd(0, 6, "R1 after step");
    tick_en = 1'b0;
    wait_n(3 * DIV);
    rd(0, 6, "R1 gated ticks");
    tick_en = 1'b1;

    // R2 R3 R4 end-of-century rollover
    wr(6, 99); wr(5, 12); wr(4, 31); wr(3, 6); wr(2, 23); wr(1, 59); wr(0, 59);
    wait_n(DIV);
    rd(0, 0, "R2 sec wrap");
    rd(1, 0, "R2 min wrap");
    rd(2, 0, "R2 hour wrap");
    rd(3, 0, "R4 weekday wrap");
    rd(4, 1, "R3 date wrap");
    rd(5, 1, "R4 month wrap");
    rd(6, 0, "R4 year wrap");

    // R3 leap and short months
    wr(6, 24); wr(5, 2); wr(4, 28); wr(2, 23); wr(1, 59); wr(0, 59);
    wait_n(DIV);
    rd(0, 0, "R3 capture");
    rd(4, 29, "R3 leap day");
    wr(2, 23); wr(1, 59); wr(0, 59);
    wait_n(DIV);
    rd(0, 0, "R3 capture");
    rd(4, 1, "R3 leap end date");
    rd(5, 3, "R3 leap end month");
    wr(6, 23); wr(5, 2); wr(4, 28); wr(2, 23); wr(1, 59); wr(0, 59);
    wait_n(DIV);
    rd(0, 0, "R3 capture");
    rd(4, 1, "R3 common year date");
    rd(5, 3, "R3 common year month");
    wr(5, 4); wr(4, 30); wr(2, 23); wr(1, 59); wr(0, 59);
    wait_n(DIV);
    rd(0, 0, "R3 capture");
    rd(5, 5, "R3 thirty-day month");

    // R9 holding register
    wr(1, 10); wr(0, 59);
    wait_n(DIV - 10);
    rd(0, 59, "R9 live seconds");
    wait_n(20);
    rd(1, 10, "R9 held minutes");
    rd(0, 0, "R9 new capture");
    rd(1, 11, "R9 refreshed minutes");

    // R5 R7 alarm on seconds and minutes
    wr(7, 2); wr(8, 11); wr(9, 5); wr(12, 3); wr(14, 6); wr(0, 0);
    wait_n(2 * DIV - 1);
    chk("R5 before match", int'(irq), 0);
    wait_n(1);
    chk("R5 match", int'(irq), 1);
    chk("R7 pin", int'(alarm_pin), 1);

    // R6 sticky and clear
    wait_n(3 * DIV);
    chk("R6 sticky", int'(irq), 1);
    wr(14, 7);
    chk("R6 cleared", int'(irq), 0);
    rd(14, 6, "R6 control readback");

    // R5 disabled field ignored, R7 irq gating
    wr(8, 30); wr(12, 1); wr(14, 4); wr(0, 0);
    wait_n(2 * DIV + 1);
    chk("R7 irq masked", int'(irq), 0);
    chk("R7 pin only", int'(alarm_pin), 1);
    rd(14, 5, "R5 disabled minute field");

    // R5 empty mask never matches
    wr(14, 7); wr(12, 0); wr(0, 0);
    wait_n(3 * DIV);
    chk("R5 empty mask", int'(alarm_pin), 0);

    // R8 trim both ways
    wr(13, 10); wr(0, 59);
    wait_n(2 * DIV + 4);
    rd(0, 0, "R8 positive trim long second");
    wait_n(8);
    rd(0, 1, "R8 positive trim ends");
    wr(13, 246); wr(0, 59);
    wait_n(2 * DIV - 6);
    rd(0, 1, "R8 negative trim short second");
    rd(13, 246, "R8 trim readback");

    // R10 write on the step cycle drops the step
    wr(13, 0); wr(0, 30);
    wait_n(DIV - 1);
    wr(1, 40);
    rd(0, 30, "R10 dropped step");
    rd(1, 40, "R10 written minutes");
    rd(7, 2, "R10 alarm seconds readback");

    wait_n(5);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule